// File: doc/BRIEF.md
# Next Fetch Block Final Selector

This block is the last stage of an ahead-pipelined generator of fetch-block addresses. In each advancing cycle it chooses the address of the next fetch block from four candidates: the sequential successor of the current block, one of several branch-target-buffer targets, the indirect-jump predictor target, and the top of an internal return-address stack. The real decode of the current block is not ready this late, so the choice is steered by a predicted decode byte that travels with each block.

The predicted decode byte comes from different places depending on how a block was reached. A block reached through a BTB slot or the jump predictor takes the decode byte carried by that entry. A block reached by a return takes it from a return decode table. That table is read one cycle early at the stack top of that cycle. A sequential block after a taken transfer uses a second byte that the entry supplied along with the target. A sequential block after another sequential block uses a two-block-ahead table, indexed by the address of the block two steps back. A decode-stage comparison flags misfetches. Either a misfetch or an external misprediction reloads the selector's inputs from a checkpoint, so the next block leaves without a bubble.

Top module: `nfb_final_select`

## Requirements
- R1: After synchronous active-low reset, `blk_addr` is 0, `blk_dec` is 0 and `misfetch` is 0.
- R2: When `adv` is 0 and no restore is requested, `blk_addr` and `blk_dec` keep their values.
- R3: A decode byte has the exit kind in bits [7:6] (00 sequential, 01 conditional, 10 jump, 11 return), a call flag in bit 5 and a slot index in bits [4:0]. On an advance with kind 00, or with kind 01 and `cond_taken` 0, the next block is `blk_addr`+1. Its decode byte comes from one of two sources. If the current block was itself reached sequentially, it is the two-block-ahead table entry at the low index bits of the block before the current one. Otherwise it is the follow-on byte supplied with the current block (jump/BTB `*_ftd`, return-table low byte, or `ck_ftd`).
- R4: On an advance with kind 01 and `cond_taken` 1, the next block is BTB slot `blk_dec[4:0]` (slot k occupies bits [k*32 +: 32] of `btb_tgt` and [k*8 +: 8] of `btb_dec`/`btb_ftd`), and its decode byte is that slot's `btb_dec`.
- R5: On an advance with kind 10, the next block is `jmp_tgt` with decode byte `jmp_dec`.
- R6: On an advance with kind 11, the next block is the stack top. Its decode byte is bits [15:8] of the return-table entry read in the previous advancing cycle at the low index bits of that cycle's stack top. The follow-on byte is bits [7:0] of the same entry. When a call block is directly followed by its return, the byte therefore belongs to the older top.
- R7: A taken transfer (kind 10, or kind 01 taken) from a block with the call flag set pushes `blk_addr`+1. A return pops. The stack holds 8 entries, and a ninth push overwrites the oldest.
- R8: `misfetch` is 1 in the same cycle that `dcd_valid` is 1 and `dcd_act` differs from `dcd_pred`, and 0 otherwise.
- R9: A restore (`mispred` or `misfetch`) loads `ck_addr`, `ck_dec`, `ck_ftd` and the stack pointer `ck_sp` at the next edge. It overrides `adv` and any push or pop of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adv | input | 1 | Fetch advances this cycle |
| cond_taken | input | 1 | Predicted direction of the conditional exit |
| btb_tgt | input | NSLOT*AW | BTB targets, one per slot |
| btb_dec | input | NSLOT*8 | Decode byte of each BTB target block |
| btb_ftd | input | NSLOT*8 | Decode byte of the block after each BTB target |
| jmp_tgt | input | AW | Jump predictor target |
| jmp_dec | input | 8 | Decode byte of the jump target block |
| jmp_ftd | input | 8 | Decode byte of the block after the jump target |
| rt_we | input | 1 | Return decode table write enable |
| rt_widx | input | IW | Return decode table write index |
| rt_wdata | input | 16 | Return decode table entry |
| ta_we | input | 1 | Two-ahead table write enable |
| ta_widx | input | IW | Two-ahead table write index |
| ta_wdata | input | 8 | Two-ahead table entry |
| dcd_valid | input | 1 | Decode-stage comparison valid |
| dcd_pred | input | 8 | Predicted decode byte of the decoded block |
| dcd_act | input | 8 | Actual decode byte of the decoded block |
| mispred | input | 1 | External misprediction restore request |
| ck_addr | input | AW | Checkpoint block address |
| ck_dec | input | 8 | Checkpoint decode byte |
| ck_ftd | input | 8 | Checkpoint follow-on decode byte |
| ck_sp | input | $clog2(RAS_DEPTH) | Checkpoint stack pointer |
| blk_addr | output | AW | Current fetch block address |
| blk_dec | output | 8 | Predicted decode byte of the current block |
| misfetch | output | 1 | Decode mismatch flag |

## Verification
A restore and a stack push can land on the same edge. In that case the restore must win: the stack pointer comes from the checkpoint, and the pushed address must not be written. The bench provokes this by holding a call block with a jump exit, then raising `adv` together with a decode mismatch and a checkpoint pointer of 1. It then judges the next return. That return must produce the entry already stored in slot 1 and not the pushed address. A second collision has a call block followed directly by its return. In this case the return's decode byte must come from the stale table entry of the older top.

// File: rtl/fas_pkg.sv
// Package: shared encodings for the final fetch-block selector.
// Assumes an 8-bit predicted decode byte: kind [7:6], call [5], slot [4:0].
package fas_pkg;
    localparam int DEC_W = 8;

    typedef enum logic [1:0] {
        EK_SEQ  = 2'b00,
        EK_COND = 2'b01,
        EK_JUMP = 2'b10,
        EK_RET  = 2'b11
    } exit_kind_e;

    function automatic exit_kind_e kind_of(input logic [DEC_W-1:0] d);
        return exit_kind_e'(d[7:6]);
    endfunction
endpackage

// File: rtl/fas_dectbl.sv
// Module: small decode-prediction table with one write port and a
// registered read port. Assumes ENT = 2**IW entries, cleared on reset;
// the read register only updates when re is high.
module fas_dectbl #(
    parameter int IW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rdata
);
    localparam int ENT = 1 << IW;

    logic [DW-1:0] mem [ENT];

    // Storage: clear on reset, write on we.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENT; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    // Registered read, one cycle ahead of its use.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[ridx];
    end
endmodule

// File: rtl/fas_ras.sv
// Module: circular return-address stack. Top is exposed directly from the
// entry under the pointer. Assumes DEPTH is a power of two, so the pointer
// wraps and an overflow overwrites the oldest entry. Load beats push/pop.
module fas_ras #(
    parameter int AW    = 32,
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic                     pop,
    input  logic [AW-1:0]            push_val,
    input  logic                     load,
    input  logic [$clog2(DEPTH)-1:0] load_sp,
    output logic [AW-1:0]            top
);
    localparam int PW = $clog2(DEPTH);

    logic [AW-1:0] stk [DEPTH];
    logic [PW-1:0] sp;
    logic [PW-1:0] sp_up;

    assign sp_up = sp + PW'(1);
    assign top   = stk[sp];

    // Pointer update: checkpoint load first, then push, then pop.
    always_ff @(posedge clk) begin
        if (!rst_n)    sp <= '0;
        else if (load) sp <= load_sp;
        else if (push) sp <= sp_up;
        else if (pop)  sp <= sp - PW'(1);
    end

    // Entry write on push only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
        end else if (push && !load) begin
            stk[sp_up] <= push_val;
        end
    end

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !load) |=> (sp == PW'($past(sp) + PW'(1)))) else $error("push step"); // R7
    AST_LOAD_SP: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sp == $past(load_sp))) else $error("load sp"); // R9
endmodule

// File: rtl/fas_pick.sv
// Module: combinational candidate choice for the next fetch block, steered
// by the current block's predicted decode byte. Assumes the slot field
// names a slot below NSLOT; other values fall back to slot 0.
module fas_pick
    import fas_pkg::*;
#(
    parameter int AW    = 32,
    parameter int NSLOT = 4
) (
    input  logic [AW-1:0]        cur_addr,
    input  logic [DEC_W-1:0]     cur_dec,
    input  logic                 came_seq,
    input  logic [DEC_W-1:0]     ftd_q,
    input  logic [DEC_W-1:0]     a2_q,
    input  logic [2*DEC_W-1:0]   rt_q,
    input  logic [AW-1:0]        ras_top,
    input  logic                 cond_taken,
    input  logic [NSLOT*AW-1:0]  btb_tgt,
    input  logic [NSLOT*8-1:0]   btb_dec,
    input  logic [NSLOT*8-1:0]   btb_ftd,
    input  logic [AW-1:0]        jmp_tgt,
    input  logic [DEC_W-1:0]     jmp_dec,
    input  logic [DEC_W-1:0]     jmp_ftd,
    output logic [AW-1:0]        nxt_addr,
    output logic [DEC_W-1:0]     nxt_dec,
    output logic [DEC_W-1:0]     nxt_ftd,
    output logic                 nxt_seq,
    output logic                 push,
    output logic                 pop,
    output logic [AW-1:0]        push_val
);
    logic [AW-1:0]    s_tgt [NSLOT];
    logic [DEC_W-1:0] s_dec [NSLOT];
    logic [DEC_W-1:0] s_ftd [NSLOT];
    logic [AW-1:0]    b_tgt;
    logic [DEC_W-1:0] b_dec;
    logic [DEC_W-1:0] b_ftd;
    exit_kind_e       kind;
    logic             is_call;

    // Unpack the flat BTB buses into per-slot views.
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign s_tgt[g] = btb_tgt[g*AW +: AW];
        assign s_dec[g] = btb_dec[g*8 +: 8];
        assign s_ftd[g] = btb_ftd[g*8 +: 8];
    end

    assign kind     = kind_of(cur_dec);
    assign is_call  = cur_dec[5];
    assign push_val = cur_addr + AW'(1);

    // Slot select by comparing the full slot field against each slot number.
    always_comb begin
        b_tgt = s_tgt[0];
        b_dec = s_dec[0];
        b_ftd = s_ftd[0];
        for (int k = 1; k < NSLOT; k++) begin
            if (cur_dec[4:0] == 5'(k)) begin
                b_tgt = s_tgt[k];
                b_dec = s_dec[k];
                b_ftd = s_ftd[k];
            end
        end
    end

    // Final selection among sequential, BTB, jump and return candidates.
    always_comb begin
        nxt_addr = push_val;
        nxt_dec  = came_seq ? a2_q : ftd_q;
        nxt_ftd  = '0;
        nxt_seq  = 1'b1;
        push     = 1'b0;
        pop      = 1'b0;
        unique case (kind)
            EK_COND: if (cond_taken) begin
                nxt_addr = b_tgt;
                nxt_dec  = b_dec;
                nxt_ftd  = b_ftd;
                nxt_seq  = 1'b0;
                push     = is_call;
            end
            EK_JUMP: begin
                nxt_addr = jmp_tgt;
                nxt_dec  = jmp_dec;
                nxt_ftd  = jmp_ftd;
                nxt_seq  = 1'b0;
                push     = is_call;
            end
            EK_RET: begin
                nxt_addr = ras_top;
                nxt_dec  = rt_q[2*DEC_W-1:DEC_W];
                nxt_ftd  = rt_q[DEC_W-1:0];
                nxt_seq  = 1'b0;
                pop      = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nfb_final_select.sv
// Module: final stage of an ahead-pipelined fetch-block address generator.
// Holds the current block and its predicted decode byte, the return stack
// and both decode tables; picks the next block each advancing cycle and
// reloads from a checkpoint on misfetch or misprediction. Assumes NSLOT and
// RAS_DEPTH are powers of two and tables are indexed by low address bits.
module nfb_final_select
    import fas_pkg::*;
#(
    parameter int AW        = 32,
    parameter int NSLOT     = 4,
    parameter int IW        = 4,
    parameter int RAS_DEPTH = 8,
    parameter logic [AW-1:0] RST_ADDR = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         adv,
    input  logic                         cond_taken,
    input  logic [NSLOT*AW-1:0]          btb_tgt,
    input  logic [NSLOT*8-1:0]           btb_dec,
    input  logic [NSLOT*8-1:0]           btb_ftd,
    input  logic [AW-1:0]                jmp_tgt,
    input  logic [7:0]                   jmp_dec,
    input  logic [7:0]                   jmp_ftd,
    input  logic                         rt_we,
    input  logic [IW-1:0]                rt_widx,
    input  logic [15:0]                  rt_wdata,
    input  logic                         ta_we,
    input  logic [IW-1:0]                ta_widx,
    input  logic [7:0]                   ta_wdata,
    input  logic                         dcd_valid,
    input  logic [7:0]                   dcd_pred,
    input  logic [7:0]                   dcd_act,
    input  logic                         mispred,
    input  logic [AW-1:0]                ck_addr,
    input  logic [7:0]                   ck_dec,
    input  logic [7:0]                   ck_ftd,
    input  logic [$clog2(RAS_DEPTH)-1:0] ck_sp,
    output logic [AW-1:0]                blk_addr,
    output logic [7:0]                   blk_dec,
    output logic                         misfetch
);
    logic [DEC_W-1:0]   ftd_q;
    logic               came_seq;
    logic [DEC_W-1:0]   a2_q;
    logic [2*DEC_W-1:0] rt_q;
    logic [AW-1:0]      ras_top;
    logic               restore;
    logic [AW-1:0]      nxt_addr;
    logic [DEC_W-1:0]   nxt_dec;
    logic [DEC_W-1:0]   nxt_ftd;
    logic               nxt_seq;
    logic               pk_push;
    logic               pk_pop;
    logic [AW-1:0]      push_val;
    logic               go;

    assign misfetch = dcd_valid && (dcd_act != dcd_pred);
    assign restore  = misfetch || mispred;
    assign go       = adv && !restore;

    fas_pick #(.AW(AW), .NSLOT(NSLOT)) u_pick (
        .cur_addr(blk_addr), .cur_dec(blk_dec), .came_seq(came_seq),
        .ftd_q(ftd_q), .a2_q(a2_q), .rt_q(rt_q), .ras_top(ras_top),
        .cond_taken(cond_taken), .btb_tgt(btb_tgt), .btb_dec(btb_dec),
        .btb_ftd(btb_ftd), .jmp_tgt(jmp_tgt), .jmp_dec(jmp_dec),
        .jmp_ftd(jmp_ftd), .nxt_addr(nxt_addr), .nxt_dec(nxt_dec),
        .nxt_ftd(nxt_ftd), .nxt_seq(nxt_seq), .push(pk_push),
        .pop(pk_pop), .push_val(push_val)
    );

    fas_ras #(.AW(AW), .DEPTH(RAS_DEPTH)) u_ras (
        .clk(clk), .rst_n(rst_n), .push(go && pk_push), .pop(go && pk_pop),
        .push_val(push_val), .load(restore), .load_sp(ck_sp), .top(ras_top)
    );

    // Return decode table: read at this cycle's top, used next cycle.
    fas_dectbl #(.IW(IW), .DW(2*DEC_W)) u_rtbl (
        .clk(clk), .rst_n(rst_n), .we(rt_we), .widx(rt_widx),
        .wdata(rt_wdata), .re(adv), .ridx(ras_top[IW-1:0]), .rdata(rt_q)
    );

    // Two-ahead table: read at block A, used when A+1 picks A+2.
    fas_dectbl #(.IW(IW), .DW(DEC_W)) u_atbl (
        .clk(clk), .rst_n(rst_n), .we(ta_we), .widx(ta_widx),
        .wdata(ta_wdata), .re(adv), .ridx(blk_addr[IW-1:0]), .rdata(a2_q)
    );

    // Current block state: checkpoint reload beats advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_addr <= RST_ADDR;
            blk_dec  <= '0;
            ftd_q    <= '0;
            came_seq <= 1'b0;
        end else if (restore) begin
            blk_addr <= ck_addr;
            blk_dec  <= ck_dec;
            ftd_q    <= ck_ftd;
            came_seq <= 1'b0;
        end else if (adv) begin
            blk_addr <= nxt_addr;
            blk_dec  <= nxt_dec;
            ftd_q    <= nxt_ftd;
            came_seq <= nxt_seq;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !restore) |=> ($stable(blk_addr) && $stable(blk_dec))) else $error("hold"); // R2
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (go && kind_of(blk_dec) == EK_SEQ) |=> (blk_addr == $past(blk_addr) + AW'(1))) else $error("seq"); // R3
    AST_JUMP_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        (go && kind_of(blk_dec) == EK_JUMP) |=> (blk_addr == $past(jmp_tgt))) else $error("jump"); // R5
    AST_RET_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        (go && kind_of(blk_dec) == EK_RET) |=> (blk_addr == $past(ras_top))) else $error("ret"); // R6
    AST_RESTORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (blk_addr == $past(ck_addr) && blk_dec == $past(ck_dec))) else $error("restore"); // R9
endmodule

// File: tb/tb_nfb_final_select.sv
module tb_nfb_final_select;
    localparam int AW = 32;
    localparam int NS = 4;
    localparam int IW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic adv = 1'b0, cond_taken = 1'b0;
    logic [NS*AW-1:0] btb_tgt = '0;
    logic [NS*8-1:0]  btb_dec = '0, btb_ftd = '0;
    logic [AW-1:0] jmp_tgt = '0;
    logic [7:0] jmp_dec = '0, jmp_ftd = '0;
    logic rt_we = 1'b0; logic [IW-1:0] rt_widx = '0; logic [15:0] rt_wdata = '0;
    logic ta_we = 1'b0; logic [IW-1:0] ta_widx = '0; logic [7:0] ta_wdata = '0;
    logic dcd_valid = 1'b0; logic [7:0] dcd_pred = '0, dcd_act = '0;
    logic mispred = 1'b0;
    logic [AW-1:0] ck_addr = '0; logic [7:0] ck_dec = '0, ck_ftd = '0; logic [2:0] ck_sp = '0;
    logic [AW-1:0] blk_addr; logic [7:0] blk_dec; logic misfetch;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nfb_final_select #(.AW(AW), .NSLOT(NS), .IW(IW), .RAS_DEPTH(8)) dut (
        .clk(clk), .rst_n(rst_n), .adv(adv), .cond_taken(cond_taken),
        .btb_tgt(btb_tgt), .btb_dec(btb_dec), .btb_ftd(btb_ftd),
        .jmp_tgt(jmp_tgt), .jmp_dec(jmp_dec), .jmp_ftd(jmp_ftd),
        .rt_we(rt_we), .rt_widx(rt_widx), .rt_wdata(rt_wdata),
        .ta_we(ta_we), .ta_widx(ta_widx), .ta_wdata(ta_wdata),
        .dcd_valid(dcd_valid), .dcd_pred(dcd_pred), .dcd_act(dcd_act),
        .mispred(mispred), .ck_addr(ck_addr), .ck_dec(ck_dec),
        .ck_ftd(ck_ftd), .ck_sp(ck_sp), .blk_addr(blk_addr),
        .blk_dec(blk_dec), .misfetch(misfetch)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic restore(input logic [31:0] a, input logic [7:0] d,
                           input logic [7:0] f, input logic [2:0] s);
        adv = 1'b0; mispred = 1'b1;
        ck_addr = a; ck_dec = d; ck_ftd = f; ck_sp = s;
        step();
        mispred = 1'b0;
        check("R9 restore addr", blk_addr, a);
        check("R9 restore dec", {24'd0, blk_dec}, {24'd0, d});
    endtask

    task automatic wr_rt(input logic [IW-1:0] i, input logic [15:0] v);
        adv = 1'b0; rt_we = 1'b1; rt_widx = i; rt_wdata = v;
        step();
        rt_we = 1'b0;
    endtask

    task automatic wr_ta(input logic [IW-1:0] i, input logic [7:0] v);
        adv = 1'b0; ta_we = 1'b1; ta_widx = i; ta_wdata = v;
        step();
        ta_we = 1'b0;
    endtask

    // R1: reset values.
    task automatic t_reset();
        check("R1 addr", blk_addr, 32'h0);
        check("R1 dec", {24'd0, blk_dec}, 32'h0);
        check("R1 misfetch", {31'd0, misfetch}, 32'h0);
    endtask

    // R3 two-ahead and entry follow-on, R5 jump, R2 hold.
    task automatic t_seq_jump();
        wr_ta(4'd5, 8'h80);
        restore(32'h5, 8'h00, 8'h04, 3'd0);
        adv = 1'b1;
        step();
        check("R3 seq addr", blk_addr, 32'h6);
        check("R3 follow-on dec", {24'd0, blk_dec}, 32'h04);
        step();
        check("R3 seq addr 2", blk_addr, 32'h7);
        check("R3 two-ahead dec", {24'd0, blk_dec}, 32'h80);
        jmp_tgt = 32'h40; jmp_dec = 8'hC0; jmp_ftd = 8'h00;
        step();
        check("R5 jump addr", blk_addr, 32'h40);
        check("R5 jump dec", {24'd0, blk_dec}, 32'hC0);
        adv = 1'b0;
        step(); step();
        check("R2 hold addr", blk_addr, 32'h40);
        check("R2 hold dec", {24'd0, blk_dec}, 32'hC0);
    endtask

    // R6/R7: call then return in adjacent blocks uses stale table entry.
    task automatic t_adjacent_ret();
        wr_rt(4'd0, 16'h0102);
        wr_rt(4'd1, 16'h4455);
        restore(32'h10, 8'hA0, 8'h00, 3'd0);
        jmp_tgt = 32'h30; jmp_dec = 8'hC0; jmp_ftd = 8'h00; adv = 1'b1;
        step();
        check("R5 call jump addr", blk_addr, 32'h30);
        step();
        check("R7 pushed return addr", blk_addr, 32'h11);
        check("R6 stale return dec", {24'd0, blk_dec}, 32'h01);
        step();
        check("R3 after return addr", blk_addr, 32'h12);
        check("R3 after return dec", {24'd0, blk_dec}, 32'h02);
        adv = 1'b0;
    endtask

    // R6: return one block later reads the table at the pushed top.
    task automatic t_far_ret();
        restore(32'h20, 8'hA0, 8'h00, 3'd0);
        jmp_tgt = 32'h50; jmp_dec = 8'h00; jmp_ftd = 8'hC0; adv = 1'b1;
        step();
        step();
        check("R3 entry follow-on dec", {24'd0, blk_dec}, 32'hC0);
        step();
        check("R6 return addr", blk_addr, 32'h21);
        check("R6 return dec", {24'd0, blk_dec}, 32'h44);
        adv = 1'b0;
    endtask

    // R4: conditional taken picks slot 2; not taken falls through.
    task automatic t_cond();
        btb_tgt[2*AW +: AW] = 32'h99; btb_dec[2*8 +: 8] = 8'h0B;
        restore(32'h60, 8'h42, 8'h13, 3'd0);
        cond_taken = 1'b1; adv = 1'b1;
        step();
        check("R4 taken addr", blk_addr, 32'h99);
        check("R4 taken dec", {24'd0, blk_dec}, 32'h0B);
        restore(32'h60, 8'h42, 8'h13, 3'd0);
        cond_taken = 1'b0; adv = 1'b1;
        step();
        check("R3 not-taken addr", blk_addr, 32'h61);
        check("R3 not-taken dec", {24'd0, blk_dec}, 32'h13);
        adv = 1'b0;
    endtask

    // R7: nine pushes wrap the 8-entry stack.
    task automatic t_wrap();
        wr_rt(4'd1, 16'hC0C0);
        restore(32'h100, 8'hA0, 8'h00, 3'd0);
        adv = 1'b1;
        for (int i = 0; i < 9; i++) begin
            jmp_tgt = 32'h110 + 32'(i) * 32'h10;
            jmp_dec = (i == 8) ? 8'hC0 : 8'hA0;
            step();
        end
        check("R7 ret block addr", blk_addr, 32'h190);
        step();
        check("R7 wrap newest", blk_addr, 32'h181);
        step();
        check("R7 wrap next", blk_addr, 32'h171);
        step();
        check("R7 wrap around", blk_addr, 32'h161);
        adv = 1'b0;
    endtask

    // R8/R9: misfetch flag and restore colliding with a push.
    task automatic t_misfetch();
        restore(32'h200, 8'hA0, 8'h00, 3'd0);
        dcd_valid = 1'b0; dcd_pred = 8'h80; dcd_act = 8'h00;
        #1 check("R8 invalid no flag", {31'd0, misfetch}, 32'h0);
        dcd_valid = 1'b1; dcd_act = 8'h80;
        #1 check("R8 match no flag", {31'd0, misfetch}, 32'h0);
        dcd_act = 8'h00;
        #1 check("R8 mismatch flag", {31'd0, misfetch}, 32'h1);
        jmp_tgt = 32'h777; jmp_dec = 8'h00;
        ck_addr = 32'h300; ck_dec = 8'hC0; ck_ftd = 8'h00; ck_sp = 3'd1;
        adv = 1'b1;
        step();
        dcd_valid = 1'b0;
        check("R9 restore beats adv", blk_addr, 32'h300);
        step();
        check("R9 push suppressed", blk_addr, 32'h181);
        adv = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(); step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_seq_jump();
        t_adjacent_ret();
        t_far_ret();
        t_cond();
        t_wrap();
        t_misfetch();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule